// File: doc/BRIEF.md
# Least-Reliable Position Insertion Sorter

This block follows a stream of received symbols, one per clock, and keeps the positions whose reliability values are lowest seen so far in the current frame. Each accepted symbol carries four things: a reliability value, its position index, the hard-decided symbol and the alternative symbol. The block keeps a fixed number of these entries in a register array, sorted by ascending reliability. The least reliable entry is at slot 0. When the frame ends, the array holds the set of least-reliable positions, and a later stage reads all slots in parallel to build its candidate words.

The array is split into two parts. A control plane holds the reliabilities, compares the incoming value against every stored one in parallel, and produces one-hot insert controls and thermometer shift controls. A data plane is a row of cells. Each cell is steered by those controls: it either holds its value, takes its neighbour's value, or loads the new payload. The start-of-frame strobe clears the array in the same cycle that the first symbol is accepted. A single-cycle done flag marks the end of the frame.

Top module: `lrp_sorter`

## Requirements
- R1: After reset, every slot reliability equals the all-ones maximum (63 at the default 6-bit width), every index and symbol field is 0, and `out_done` is 0.
- R2: At every cycle the slot reliabilities are non-decreasing from slot 0 upward. Slot k occupies bits [k*W +: W] of each flat output bus, where W is that field's width.
- R3: An accepted symbol whose reliability is strictly below some stored value is written at the first slot whose stored value is greater. Every entry from that slot upward moves up one slot, and the entry that was in the last slot is lost. At most one slot is written per cycle.
- R4: A symbol whose reliability equals one or more stored values is placed after all of them, so entries with equal reliability keep their arrival order.
- R5: A symbol whose reliability is not below any stored value leaves the array unchanged. In particular, a symbol carrying the maximum reliability never enters.
- R6: While `in_valid` is 0 the array does not change, and `in_sof` has no effect.
- R7: When `in_valid` and `in_sof` are both 1, the block treats all slots as preset (maximum reliability, zero payload) before it places that symbol. As a result, the symbol lands alone in slot 0 unless its reliability is the maximum.
- R8: `out_done` is 1 for exactly one cycle: the cycle after the FRAME_LEN-th symbol accepted since the last start-of-frame. A new start-of-frame restarts the count, so an abandoned shorter frame produces no done.
- R9: The index, hard symbol and alternative symbol of an entry always travel in the same slot as its reliability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A symbol is presented this cycle |
| in_sof | input | 1 | First symbol of a new frame (qualified by in_valid) |
| in_rel | input | REL_W | Reliability of the symbol, lower means less trusted |
| in_idx | input | IDX_W | Position index of the symbol in the frame |
| in_sym_hd | input | SYM_W | Hard-decided symbol value |
| in_sym_alt | input | SYM_W | Second-choice symbol value |
| out_rel | output | DEPTH*REL_W | Slot reliabilities, slot k at [k*REL_W +: REL_W] |
| out_idx | output | DEPTH*IDX_W | Slot position indices |
| out_sym_hd | output | DEPTH*SYM_W | Slot hard symbols |
| out_sym_alt | output | DEPTH*SYM_W | Slot alternative symbols |
| out_done | output | 1 | One-cycle pulse after the last symbol of a frame |

## Verification
Several input patterns are used, and each one aims at a boundary of the sorter:
- A strictly descending reliability stream forces an insert at slot 0 on every cycle. A shift path that is off by one would duplicate or drop an entry.
- A stream of identical values checks the tie rule. A design that used "greater or equal" would keep the latest arrivals instead of the first ones.
- Frames dominated by the maximum value check that preset slots are never overwritten by a maximum-reliability symbol.
- Idle cycles with a stray start-of-frame check that an unqualified strobe cannot wipe the array.
- A frame that is abandoned part-way and restarted checks that the done pulse follows the restarted count and not a stale one.

// File: rtl/lrp_pkg.sv
package lrp_pkg;

  typedef enum logic [1:0] {
    CELL_HOLD  = 2'd0,
    CELL_SHIFT = 2'd1,
    CELL_LOAD  = 2'd2
  } cell_op_e;

  // Load has priority: the insert slot never also receives a shift.
  function automatic cell_op_e op_select(input logic ins, input logic shf);
    if (ins)      return CELL_LOAD;
    else if (shf) return CELL_SHIFT;
    else          return CELL_HOLD;
  endfunction

endpackage

// File: rtl/lrp_ctrl.sv
module lrp_ctrl #(
  parameter int DEPTH = 16,
  parameter int REL_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     clear,
  input  logic [REL_W-1:0]         new_rel,
  output logic [DEPTH-1:0]         ins_vec,
  output logic [DEPTH-1:0]         shf_vec,
  output logic [DEPTH*REL_W-1:0]   rel_flat
);
  localparam logic [REL_W-1:0] REL_MAX = {REL_W{1'b1}};

  logic [REL_W-1:0] rel_q   [DEPTH];
  logic [REL_W-1:0] rel_cur [DEPTH];
  logic [DEPTH-1:0] gt_vec;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    // Effective stored value this cycle: preset when a frame starts.
    assign rel_cur[k] = clear ? REL_MAX : rel_q[k];
    // Strictly greater, so equal values keep the newcomer behind them.
    assign gt_vec[k]  = rel_cur[k] > new_rel;
    assign rel_flat[k*REL_W +: REL_W] = rel_q[k];

    if (k == 0) begin : g_head
      assign ins_vec[k] = in_valid & gt_vec[k];
      assign shf_vec[k] = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rel_q[k] <= REL_MAX;
        else if (ins_vec[k]) rel_q[k] <= new_rel;
        else                 rel_q[k] <= rel_cur[k];
      end
    end else begin : g_body
      assign ins_vec[k] = in_valid & gt_vec[k] & ~gt_vec[k-1];
      assign shf_vec[k] = in_valid & gt_vec[k-1];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rel_q[k] <= REL_MAX;
        else if (ins_vec[k]) rel_q[k] <= new_rel;
        else if (shf_vec[k]) rel_q[k] <= rel_cur[k-1];
        else                 rel_q[k] <= rel_cur[k];
      end
    end
  end
endmodule

// File: rtl/lrp_cell.sv
module lrp_cell
  import lrp_pkg::*;
#(
  parameter int PL_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  cell_op_e        op,
  input  logic [PL_W-1:0] new_pl,
  input  logic [PL_W-1:0] nbr_pl,
  output logic [PL_W-1:0] cur_pl,
  output logic [PL_W-1:0] q_pl
);
  assign cur_pl = clear ? '0 : q_pl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_pl <= '0;
    else begin
      case (op)
        CELL_LOAD:  q_pl <= new_pl;
        CELL_SHIFT: q_pl <= nbr_pl;
        default:    q_pl <= cur_pl;
      endcase
    end
  end
endmodule

// File: rtl/lrp_frame_cnt.sv
module lrp_frame_cnt #(
  parameter int FRAME_LEN = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sof,
  output logic last_hit,
  output logic done
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q, base;

  assign base     = in_sof ? '0 : cnt_q;
  assign last_hit = in_valid & (base == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_hit;
      if (in_valid && base != LEN_C) cnt_q <= base + 1'b1;
      else if (in_valid)             cnt_q <= base;
    end
  end
endmodule

// File: rtl/lrp_sorter.sv
module lrp_sorter
  import lrp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int REL_W     = 6,
  parameter int IDX_W     = 8,
  parameter int SYM_W     = 8,
  parameter int FRAME_LEN = 255
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic [REL_W-1:0]       in_rel,
  input  logic [IDX_W-1:0]       in_idx,
  input  logic [SYM_W-1:0]       in_sym_hd,
  input  logic [SYM_W-1:0]       in_sym_alt,
  output logic [DEPTH*REL_W-1:0] out_rel,
  output logic [DEPTH*IDX_W-1:0] out_idx,
  output logic [DEPTH*SYM_W-1:0] out_sym_hd,
  output logic [DEPTH*SYM_W-1:0] out_sym_alt,
  output logic                   out_done
);
  localparam int PL_W = IDX_W + 2 * SYM_W;

  // Named internal events for the checker.
  logic             clear;
  logic [DEPTH-1:0] ins_vec;
  logic [DEPTH-1:0] shf_vec;
  logic             last_hit;

  assign clear = in_valid & in_sof;

  lrp_ctrl #(.DEPTH(DEPTH), .REL_W(REL_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .clear    (clear),
    .new_rel  (in_rel),
    .ins_vec  (ins_vec),
    .shf_vec  (shf_vec),
    .rel_flat (out_rel)
  );

  logic [PL_W-1:0] pl_new;
  logic [PL_W-1:0] pl_cur [DEPTH];
  logic [PL_W-1:0] pl_q   [DEPTH];

  assign pl_new = {in_idx, in_sym_hd, in_sym_alt};

  for (genvar k = 0; k < DEPTH; k++) begin : g_cell
    logic [PL_W-1:0] nbr;
    if (k == 0) begin : g_first
      assign nbr = '0;
    end else begin : g_rest
      assign nbr = pl_cur[k-1];
    end

    lrp_cell #(.PL_W(PL_W)) cell_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clear),
      .op     (op_select(ins_vec[k], shf_vec[k])),
      .new_pl (pl_new),
      .nbr_pl (nbr),
      .cur_pl (pl_cur[k]),
      .q_pl   (pl_q[k])
    );

    assign out_idx[k*IDX_W +: IDX_W]     = pl_q[k][PL_W-1 -: IDX_W];
    assign out_sym_hd[k*SYM_W +: SYM_W]  = pl_q[k][2*SYM_W-1 -: SYM_W];
    assign out_sym_alt[k*SYM_W +: SYM_W] = pl_q[k][SYM_W-1:0];
  end

  lrp_frame_cnt #(.FRAME_LEN(FRAME_LEN)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .last_hit (last_hit),
    .done     (out_done)
  );
endmodule

// File: rtl/lrp_sorter_chk.sv
module lrp_sorter_chk #(
  parameter int DEPTH = 16,
  parameter int REL_W = 6,
  parameter int IDX_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_sof,
  input logic [REL_W-1:0]       in_rel,
  input logic [DEPTH*REL_W-1:0] out_rel,
  input logic [DEPTH*IDX_W-1:0] out_idx,
  input logic                   out_done,
  input logic [DEPTH-1:0]       ins_vec
);
  localparam logic [REL_W-1:0] REL_MAX = {REL_W{1'b1}};

  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_ord
    a_r2_sorted: assert property (@(posedge clk) disable iff (!rst_n)
      out_rel[k*REL_W +: REL_W] <= out_rel[(k+1)*REL_W +: REL_W]);
  end

  a_r3_single_insert: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ins_vec));

  a_r5_max_never_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_rel == REL_MAX) |-> (ins_vec == '0));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_rel) && $stable(out_idx)));

  a_r7_sof_front: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && in_rel != REL_MAX)
      |=> (out_rel[REL_W-1:0] == $past(in_rel)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  a_r8_done_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(in_valid));
endmodule

bind lrp_sorter lrp_sorter_chk #(.DEPTH(DEPTH), .REL_W(REL_W), .IDX_W(IDX_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_sof   (in_sof),
  .in_rel   (in_rel),
  .out_rel  (out_rel),
  .out_idx  (out_idx),
  .out_done (out_done),
  .ins_vec  (ins_vec)
);

// File: tb/lrp_sorter_tb_top.sv
module lrp_sorter_tb_top;
  localparam int DEPTH = 16, REL_W = 6, IDX_W = 8, SYM_W = 8, FRAME_LEN = 255;
  localparam int RMAX = (1 << REL_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [REL_W-1:0] in_rel = '0;
  logic [IDX_W-1:0] in_idx = '0;
  logic [SYM_W-1:0] in_sym_hd = '0, in_sym_alt = '0;
  logic [DEPTH*REL_W-1:0] out_rel;
  logic [DEPTH*IDX_W-1:0] out_idx;
  logic [DEPTH*SYM_W-1:0] out_sym_hd, out_sym_alt;
  logic out_done;

  always #10 clk = ~clk;  // 50 MHz

  lrp_sorter #(.DEPTH(DEPTH), .REL_W(REL_W), .IDX_W(IDX_W), .SYM_W(SYM_W),
               .FRAME_LEN(FRAME_LEN)) dut_i (.*);

  typedef struct {
    int    due;
    int    rel [DEPTH];
    int    idx [DEPTH];
    int    hd  [DEPTH];
    int    alt [DEPTH];
    bit    done;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, total = 0, bad = 0;
  int m_rel[DEPTH], m_idx[DEPTH], m_hd[DEPTH], m_alt[DEPTH];
  int b_cnt = 0;
  bit fin = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < DEPTH; k++) begin
      m_rel[k] = RMAX; m_idx[k] = 0; m_hd[k] = 0; m_alt[k] = 0;
    end
  endtask

  // Reference insert: walk from the top, move entries up while they exceed r.
  task automatic model_put(input int r, input int i, input int h, input int a);
    int p;
    p = DEPTH;
    for (int k = DEPTH - 1; k >= 0; k--) if (m_rel[k] > r) p = k;
    if (p < DEPTH) begin
      for (int k = DEPTH - 1; k > p; k--) begin
        m_rel[k] = m_rel[k-1]; m_idx[k] = m_idx[k-1];
        m_hd[k]  = m_hd[k-1];  m_alt[k] = m_alt[k-1];
      end
      m_rel[p] = r; m_idx[p] = i; m_hd[p] = h; m_alt[p] = a;
    end
  endtask

  // Driver: presents one cycle of input and pushes the state expected after it.
  task automatic drive(input bit v, input bit s, input int r, input int i,
                       input string tag);
    exp_t e;
    int h, a;
    h = $urandom % 256;
    a = h ^ (1 << (i % SYM_W));
    @(negedge clk);
    in_valid = v; in_sof = s; in_rel = REL_W'(r); in_idx = IDX_W'(i);
    in_sym_hd = SYM_W'(h); in_sym_alt = SYM_W'(a);
    e.done = 0;
    if (v) begin
      if (s) begin model_clear(); b_cnt = 0; end
      model_put(r, i, h, a);
      if (b_cnt < FRAME_LEN) begin
        b_cnt++;
        e.done = (b_cnt == FRAME_LEN);
      end
    end
    e.rel = m_rel; e.idx = m_idx; e.hd = m_hd; e.alt = m_alt;
    e.due = cyc + 1;
    e.tag = e.done ? "R8" : tag;
    q.push_back(e);
  endtask

  // Monitor: compares the due item against the ports between edges.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      bit ok;
      e = q.pop_front();
      ok = 1;
      for (int k = 0; k < DEPTH; k++) begin
        if (ok && int'(out_rel[k*REL_W +: REL_W]) != e.rel[k]) begin
          ok = 0; check(0, e.tag, $sformatf("rel[%0d]", k),
                        int'(out_rel[k*REL_W +: REL_W]), e.rel[k]);
        end
        if (ok && int'(out_idx[k*IDX_W +: IDX_W]) != e.idx[k]) begin
          ok = 0; check(0, "R9", $sformatf("idx[%0d]", k),
                        int'(out_idx[k*IDX_W +: IDX_W]), e.idx[k]);
        end
        if (ok && int'(out_sym_hd[k*SYM_W +: SYM_W]) != e.hd[k]) begin
          ok = 0; check(0, "R9", $sformatf("hd[%0d]", k),
                        int'(out_sym_hd[k*SYM_W +: SYM_W]), e.hd[k]);
        end
        if (ok && int'(out_sym_alt[k*SYM_W +: SYM_W]) != e.alt[k]) begin
          ok = 0; check(0, "R9", $sformatf("alt[%0d]", k),
                        int'(out_sym_alt[k*SYM_W +: SYM_W]), e.alt[k]);
        end
      end
      if (ok) check(1, e.tag, "slots", 0, 0);
      check(out_done == e.done, "R8", "done", int'(out_done), int'(e.done));
      // R2 ordering seen directly at the ports
      for (int k = 0; k < DEPTH - 1; k++)
        if (out_rel[k*REL_W +: REL_W] > out_rel[(k+1)*REL_W +: REL_W])
          check(0, "R2", $sformatf("order[%0d]", k),
                int'(out_rel[k*REL_W +: REL_W]),
                int'(out_rel[(k+1)*REL_W +: REL_W]));
    end
  end

  initial begin
    #(20 * 100000);
    check(0, "watchdog", "timeout", cyc, 0);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < DEPTH; k++) begin
      check(int'(out_rel[k*REL_W +: REL_W]) == RMAX, "R1", "rel",
            int'(out_rel[k*REL_W +: REL_W]), RMAX);
      check(out_idx[k*IDX_W +: IDX_W] == 0 && out_sym_hd[k*SYM_W +: SYM_W] == 0 &&
            out_sym_alt[k*SYM_W +: SYM_W] == 0, "R1", "payload",
            int'(out_idx[k*IDX_W +: IDX_W]), 0);
    end
    check(out_done == 1'b0, "R1", "done", int'(out_done), 0);

    // Frame A: random reliabilities with idle gaps carrying a stray sof (R3, R6)
    for (int i = 0; i < FRAME_LEN; i++) begin
      drive(1, i == 0, $urandom % (RMAX + 1), i, i == 0 ? "R7" : "R3");
      if (i % 7 == 3) drive(0, 1, 0, 0, "R6");
    end
    drive(0, 0, 0, 0, "R6");

    // Frame B: descending values, inserts at slot 0 and runs of ties (R3, R4)
    for (int i = 0; i < FRAME_LEN; i++)
      drive(1, i == 0, (FRAME_LEN - 1 - i) / 5, i, "R4");

    // Frame C: all equal, the first DEPTH arrivals must be kept in order (R4)
    for (int i = 0; i < FRAME_LEN; i++) drive(1, i == 0, 10, i, "R4");

    // Frame D: mostly maximum values that must never enter (R5)
    for (int i = 0; i < FRAME_LEN; i++)
      drive(1, i == 0, (i % 40 == 5) ? 7 : RMAX, i, "R5");
    drive(0, 0, 0, 0, "R5");

    // Frame E: abandoned after 100 symbols, restarted, full length (R7, R8)
    for (int i = 0; i < 100; i++) drive(1, i == 0, $urandom % 32, i, "R3");
    for (int i = 0; i < FRAME_LEN; i++)
      drive(1, i == 0, 20 + ($urandom % 40), i, i == 0 ? "R7" : "R3");
    // symbols after frame end: no second done
    for (int i = 0; i < 5; i++) drive(1, 0, 1, i, "R8");
    drive(0, 0, 0, 0, "R6");
    repeat (3) @(negedge clk);

    if (!fin) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule